// File: doc/BRIEF.md
# Single-Transfer Bus Master Controller

This block is the initiator side of a simplified pipelined memory bus. A request arrives as one-cycle `en_i` pulse. With it come a word address, a write flag, a two-bit target code and two 32-bit operands. The controller samples the request and drives an address phase for exactly one cycle. It then holds a data phase until the responder raises `ready_i`. For a write, the data on the bus is the wrapped sum of the two operands. For a read, the returned word is latched onto `rdata_o`, and `rd_done_o` pulses once.

Targets are not chosen by decoding address bits. The controller drives an explicit target code `hsel_o` together with a strobe `hsel_valid_o`. The strobe is high only while a transfer is in flight, so a downstream one-hot decoder enables no target while the bus is idle. The attribute outputs are constants set by parameters:

- size is a word,
- burst is single,
- protection is a fixed code.

Requests that arrive while a transfer is in progress are dropped.

Top module: `bus_xfer_master`

## Requirements
- R1: While `rst_ni` is low at a clock edge, the block returns to idle. After that edge `htrans_o`=2'b00, `hsel_valid_o`=0, `hwrite_o`=0, `rd_done_o`=0 and `rdata_o`=0.
- R2: An `en_i` high while idle starts an address phase in the next cycle. That phase shows `htrans_o`=2'b10 (NONSEQ) and `hsel_valid_o`=1. `haddr_o`, `hsel_o` and `hwrite_o` equal the values sampled with `en_i`.
- R3: The address phase lasts exactly one cycle. It is followed by the data phase, where `htrans_o`=2'b00 and `hsel_valid_o`=1.
- R4: While `ready_i` is low in the data phase, the data phase continues. `haddr_o`, `hwdata_o`, `hsel_o` and `hwrite_o` stay unchanged.
- R5: `ready_i` high in the data phase ends the transfer. In the next cycle `hsel_valid_o`=0 and `htrans_o`=2'b00.
- R6: For a write, `hwdata_o` equals `op_a_i`+`op_b_i` modulo 2^32 throughout the address and data phases. For example, 0xFFFFFFFF+2 gives 0x00000001.
- R7: A read that completes with `ready_i` high latches `rdata_i`. In the following cycle `rd_done_o` is high for one cycle and `rdata_o` shows the latched word.
- R8: `rdata_o` holds its value until the next read completes. A write transfer neither raises `rd_done_o` nor changes `rdata_o`.
- R9: `en_i` is ignored outside idle. A request during the address or data phase does not change the bus outputs, and it starts no transfer afterwards.
- R10: `hsize_o` is 3'b010 (word), `hburst_o` is 3'b000 (single) and `hprot_o` is 4'b0011 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Request strobe, sampled while idle |
| addr_i | input | 32 | Word address of the request |
| wr_i | input | 1 | 1 = write, 0 = read |
| sel_i | input | 2 | Target code of the request |
| op_a_i | input | 32 | First write operand |
| op_b_i | input | 32 | Second write operand |
| ready_i | input | 1 | Responder ready, ends the data phase |
| rdata_i | input | 32 | Responder read data |
| haddr_o | output | 32 | Bus address |
| hwdata_o | output | 32 | Bus write data (operand sum) |
| hwrite_o | output | 1 | Bus write flag, high only during a write transfer |
| htrans_o | output | 2 | Transfer type: 2'b10 in the address phase, else 2'b00 |
| hsize_o | output | 3 | Transfer size |
| hburst_o | output | 3 | Burst kind |
| hprot_o | output | 4 | Protection code |
| hsel_o | output | 2 | Target code |
| hsel_valid_o | output | 1 | Target code valid, high in address and data phases |
| rdata_o | output | 32 | Last read word |
| rd_done_o | output | 1 | One-cycle read completion pulse |

## Verification
Several rules are checked by the assertions on every clock:

- the address phase lasts one cycle and always leads into the data phase;
- an address phase only ever follows an idle cycle;
- the bus outputs stay stable during wait states;
- the strobe drops after `ready_i`;
- the write sum holds;
- `rdata_o` changes only with a completion pulse, and that pulse is a single cycle.

Other behaviours are only visible through the bench's scenarios:

- that a read returns the word an earlier write stored, for each target code;
- the correct cycle of `rd_done_o` under wait states of different lengths;
- that requests are dropped in mid-transfer;
- the reset values and constant attributes.

// File: rtl/bus_xfer_pkg.sv
package bus_xfer_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2
   } bxm_state_e;

   localparam logic [1:0] TRANS_IDLE   = 2'b00;
   localparam logic [1:0] TRANS_NONSEQ = 2'b10;
   localparam logic [2:0] BURST_SINGLE = 3'b000;
endpackage

// File: rtl/bxm_sequencer.sv
module bxm_sequencer
   import bus_xfer_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       en_i,
   input  logic       ready_i,
   output bxm_state_e state_o,
   output logic       capture_o,
   output logic       accept_o
);
   bxm_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (en_i)    state_d = ST_ADDR;
         ST_ADDR:              state_d = ST_DATA;
         ST_DATA: if (ready_i) state_d = ST_IDLE;
         default:              state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) state_q <= ST_IDLE;
      else         state_q <= state_d;
   end

   assign state_o   = state_q;
   assign capture_o = (state_q == ST_IDLE) && en_i;
   assign accept_o  = (state_q == ST_DATA) && ready_i;

   // R3: one address cycle, then data
   assert_addr_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q == ST_ADDR |=> state_q == ST_DATA);
   // R9: the address phase is entered only from idle
   assert_addr_from_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q != ST_IDLE |=> state_q != ST_ADDR);
endmodule

// File: rtl/bxm_req_regs.sv
module bxm_req_regs #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int SEL_W     = 2,
   parameter bit SUM_STAGE = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              capture_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic [DATA_W-1:0] op_a_i,
   input  logic [DATA_W-1:0] op_b_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              wr_o,
   output logic [SEL_W-1:0]  sel_o,
   output logic [DATA_W-1:0] wdata_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         addr_o <= '0;
         wr_o   <= 1'b0;
         sel_o  <= '0;
      end else if (capture_i) begin
         addr_o <= addr_i;
         wr_o   <= wr_i;
         sel_o  <= sel_i;
      end
   end

   generate
      if (SUM_STAGE) begin : g_sum_early
         logic [DATA_W-1:0] sum_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni)        sum_q <= '0;
            else if (capture_i) sum_q <= op_a_i + op_b_i;
         end
         assign wdata_o = sum_q;
      end else begin : g_sum_late
         logic [DATA_W-1:0] a_q, b_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               a_q <= '0;
               b_q <= '0;
            end else if (capture_i) begin
               a_q <= op_a_i;
               b_q <= op_b_i;
            end
         end
         assign wdata_o = a_q + b_q;
      end
   endgenerate

   // R6: write data is the wrapped sum of the operands sampled with the request
   assert_wdata_sum_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(capture_i) && $past(rst_ni) |-> wdata_o == DATA_W'($past(op_a_i) + $past(op_b_i)));
endmodule

// File: rtl/bxm_rd_capture.sv
module bxm_rd_capture #(
   parameter int DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              accept_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              done_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rdata_o <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= accept_i && !wr_i;
         if (accept_i && !wr_i) rdata_o <= rdata_i;
      end
   end

   // R7: the completion pulse lasts one cycle
   assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);
   // R8: read data changes only together with a completion pulse
   assert_rdata_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) && !done_o |-> $stable(rdata_o));
endmodule

// File: rtl/bus_xfer_master.sv
module bus_xfer_master
   import bus_xfer_pkg::*;
#(
   parameter int         ADDR_W    = 32,
   parameter int         DATA_W    = 32,
   parameter int         SEL_W     = 2,
   parameter logic [3:0] PROT      = 4'b0011,
   parameter bit         SUM_STAGE = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic [DATA_W-1:0] op_a_i,
   input  logic [DATA_W-1:0] op_b_i,
   input  logic              ready_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [ADDR_W-1:0] haddr_o,
   output logic [DATA_W-1:0] hwdata_o,
   output logic              hwrite_o,
   output logic [1:0]        htrans_o,
   output logic [2:0]        hsize_o,
   output logic [2:0]        hburst_o,
   output logic [3:0]        hprot_o,
   output logic [SEL_W-1:0]  hsel_o,
   output logic              hsel_valid_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rd_done_o
);
   localparam int BYTES_W  = DATA_W / 8;
   localparam int SIZE_LOG = $clog2(BYTES_W);

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0 || (1 << SIZE_LOG) != BYTES_W) begin : g_bad_data_w
         $error("DATA_W must be a power-of-two number of bytes");
      end
      if (ADDR_W < 1 || SEL_W < 1) begin : g_bad_widths
         $error("ADDR_W and SEL_W must be at least 1");
      end
   endgenerate

   bxm_state_e        state;
   logic              capture, accept, wr_q, active;
   logic [ADDR_W-1:0] addr_q;
   logic [SEL_W-1:0]  sel_q;

   bxm_sequencer u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i),
      .ready_i   (ready_i),
      .state_o   (state),
      .capture_o (capture),
      .accept_o  (accept)
   );

   bxm_req_regs #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .SEL_W     (SEL_W),
      .SUM_STAGE (SUM_STAGE)
   ) u_req (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .capture_i (capture),
      .addr_i    (addr_i),
      .wr_i      (wr_i),
      .sel_i     (sel_i),
      .op_a_i    (op_a_i),
      .op_b_i    (op_b_i),
      .addr_o    (addr_q),
      .wr_o      (wr_q),
      .sel_o     (sel_q),
      .wdata_o   (hwdata_o)
   );

   bxm_rd_capture #(.DATA_W(DATA_W)) u_rd (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .accept_i (accept),
      .wr_i     (wr_q),
      .rdata_i  (rdata_i),
      .rdata_o  (rdata_o),
      .done_o   (rd_done_o)
   );

   assign active       = (state != ST_IDLE);
   assign haddr_o      = addr_q;
   assign hsel_o       = sel_q;
   assign hwrite_o     = wr_q && active;
   assign hsel_valid_o = active;
   assign htrans_o     = (state == ST_ADDR) ? TRANS_NONSEQ : TRANS_IDLE;
   assign hsize_o      = 3'(SIZE_LOG);
   assign hburst_o     = BURST_SINGLE;
   assign hprot_o      = PROT;

   // R2: a request taken while idle opens an address phase next cycle
   assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hsel_valid_o && en_i |=> htrans_o == TRANS_NONSEQ && hsel_valid_o);
   // R4: bus outputs are frozen during wait states
   assert_wait_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hsel_valid_o && htrans_o == TRANS_IDLE && !ready_i |=>
         hsel_valid_o && $stable(haddr_o) && $stable(hwdata_o) && $stable(hsel_o) && $stable(hwrite_o));
   // R5: the strobe drops after the responder is ready
   assert_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hsel_valid_o && htrans_o == TRANS_IDLE && ready_i |=> !hsel_valid_o);
   // R8: no completion pulse after a write transfer
   assert_no_done_on_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hwrite_o && ready_i |=> !rd_done_o);
endmodule

// File: tb/bus_xfer_master_tb_top.sv
module bus_xfer_master_tb_top;
   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic        en = 1'b0, wr = 1'b0, ready = 1'b0;
   logic [31:0] addr = '0, op_a = '0, op_b = '0, rdata_in = '0;
   logic [1:0]  sel = '0;
   logic [31:0] haddr, hwdata, rdata_out;
   logic        hwrite, hsel_valid, rd_done;
   logic [1:0]  htrans, hsel;
   logic [2:0]  hsize, hburst;
   logic [3:0]  hprot;

   int n_checks = 0;
   int n_fail   = 0;
   logic [31:0] model_mem [4][32];
   logic [31:0] exp_q [$];
   logic [31:0] last_read = '0;

   always #5 clk = ~clk;

   bus_xfer_master dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .addr_i(addr), .wr_i(wr), .sel_i(sel),
      .op_a_i(op_a), .op_b_i(op_b), .ready_i(ready), .rdata_i(rdata_in),
      .haddr_o(haddr), .hwdata_o(hwdata), .hwrite_o(hwrite), .htrans_o(htrans),
      .hsize_o(hsize), .hburst_o(hburst), .hprot_o(hprot), .hsel_o(hsel),
      .hsel_valid_o(hsel_valid), .rdata_o(rdata_out), .rd_done_o(rd_done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on each completion pulse
   always @(negedge clk) begin
      if (rst_ni && rd_done) begin
         if (exp_q.size() == 0) chk("R8 unexpected rd_done", 32'd1, 32'd0);
         else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            chk("R7 read data", rdata_out, e);
            last_read = e;
         end
      end
   end

   task automatic xfer(input logic w, input logic [1:0] s, input logic [4:0] a,
                       input logic [31:0] x, input logic [31:0] y, input int waits,
                       input bit poke);
      @(negedge clk);
      en = 1'b1; wr = w; sel = s; addr = {27'd0, a}; op_a = x; op_b = y;
      @(negedge clk);
      en = 1'b0; addr = 32'hFFFF_FFF0; sel = ~s; wr = ~w; op_a = 32'h1; op_b = 32'h1;
      chk("R2 htrans NONSEQ", {30'd0, htrans}, 32'd2);
      chk("R2 sel_valid", {31'd0, hsel_valid}, 32'd1);
      chk("R2 haddr", haddr, {27'd0, a});
      chk("R2 hsel", {30'd0, hsel}, {30'd0, s});
      chk("R2 hwrite", {31'd0, hwrite}, {31'd0, w});
      if (w) chk("R6 wdata in address phase", hwdata, x + y);
      @(negedge clk);
      chk("R3 data phase htrans", {30'd0, htrans}, 32'd0);
      chk("R3 data phase sel_valid", {31'd0, hsel_valid}, 32'd1);
      for (int i = 0; i < waits; i++) begin
         if (poke) en = 1'b1;
         @(negedge clk);
         chk("R4 wait sel_valid", {31'd0, hsel_valid}, 32'd1);
         chk("R4 wait haddr", haddr, {27'd0, a});
         chk("R9 wait htrans", {30'd0, htrans}, 32'd0);
         if (w) chk("R4 wait wdata", hwdata, x + y);
      end
      en = 1'b0;
      ready = 1'b1;
      if (w) begin
         chk("R6 wdata in data phase", hwdata, x + y);
         model_mem[s][a] = hwdata;
      end else begin
         rdata_in = model_mem[s][a];
         exp_q.push_back(model_mem[s][a]);
      end
      @(negedge clk);
      ready = 1'b0; rdata_in = 32'hBAD0_BAD0;
      chk("R5 idle sel_valid", {31'd0, hsel_valid}, 32'd0);
      chk("R5 idle htrans", {30'd0, htrans}, 32'd0);
      chk("R8 rd_done only on read", {31'd0, rd_done}, {31'd0, ~w});
      @(negedge clk);
      chk("R7 rd_done single pulse", {31'd0, rd_done}, 32'd0);
      chk("R8 rdata held", rdata_out, last_read);
      chk("R9 no transfer from ignored request", {31'd0, hsel_valid}, 32'd0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      chk("watchdog expired", 32'd1, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int s = 0; s < 4; s++)
         for (int k = 0; k < 32; k++) model_mem[s][k] = 32'h0;
      repeat (3) @(negedge clk);
      // R1: reset state; R10 constants
      chk("R1 htrans", {30'd0, htrans}, 32'd0);
      chk("R1 sel_valid", {31'd0, hsel_valid}, 32'd0);
      chk("R1 hwrite", {31'd0, hwrite}, 32'd0);
      chk("R1 rd_done", {31'd0, rd_done}, 32'd0);
      chk("R1 rdata", rdata_out, 32'd0);
      chk("R10 hsize", {29'd0, hsize}, 32'd2);
      chk("R10 hburst", {29'd0, hburst}, 32'd0);
      chk("R10 hprot", {28'd0, hprot}, 32'd3);
      rst_ni = 1'b1;
      xfer(1'b1, 2'd0, 5'd1,  32'h1111_0000, 32'h0000_2222, 0, 1'b0);
      xfer(1'b1, 2'd1, 5'd2,  32'hA000_0001, 32'h0B00_0010, 1, 1'b0);
      xfer(1'b1, 2'd2, 5'd3,  32'hFFFF_FFFF, 32'h0000_0002, 3, 1'b1);
      xfer(1'b1, 2'd3, 5'd31, 32'h7000_0000, 32'h0777_7777, 2, 1'b0);
      xfer(1'b0, 2'd3, 5'd31, 32'h0, 32'h0, 0, 1'b0);
      xfer(1'b0, 2'd2, 5'd3,  32'h0, 32'h0, 2, 1'b1);
      xfer(1'b0, 2'd1, 5'd2,  32'h0, 32'h0, 1, 1'b0);
      xfer(1'b1, 2'd0, 5'd5,  32'h8000_0000, 32'h8000_0000, 0, 1'b0);
      xfer(1'b0, 2'd0, 5'd1,  32'h0, 32'h0, 4, 1'b1);
      xfer(1'b0, 2'd0, 5'd5,  32'h0, 32'h0, 0, 1'b0);
      chk("R10 hsize end", {29'd0, hsize}, 32'd2);
      chk("R10 hprot end", {28'd0, hprot}, 32'd3);
      chk("R7 all reads completed", exp_q.size(), 32'd0);
      // R1: mid-transfer reset
      @(negedge clk);
      en = 1'b1; wr = 1'b1;
      @(negedge clk);
      en = 1'b0; rst_ni = 1'b0;
      @(negedge clk);
      chk("R1 reset mid-transfer sel_valid", {31'd0, hsel_valid}, 32'd0);
      chk("R1 reset mid-transfer hwrite", {31'd0, hwrite}, 32'd0);
      chk("R1 reset rdata", rdata_out, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule